// File: doc/BRIEF.md
# Host Register Front End for a Dual-Bus Serial Word Transceiver

This block sits between a 16-bit host processor bus and the word encoder and the two word decoders of a dual-redundant serial transceiver. The host runs each access with an active-low strobe, a read/write select, a register select and a channel select. These choose one of four places: the transmit holding register, the receive holding register of bus A or of bus B, or a combined configuration-and-status register. A sync bit travels beside the 16 data bits in both directions. On a transmit write it selects command or data sync. On a receive read it returns the sync type of the stored word.

All host pins are sampled by the block clock. An access starts on the first clock edge at which the strobe is seen low. The channel and transmit-sync choices are the OR of a host pin and a configuration bit, so a system can steer them from software, from pins, or from both. The decoders report through single-cycle pulses: a valid word with its sync type, the start of a new word, an encoding error, and a level that shows the bus is idle. The encoder receives a one-cycle load pulse with the word, its sync type and its target bus, and it returns a ready level. A master reset input returns every register to its initial state.

Top module: `hostif_regs`

## Requirements
- R1: With `reg_sel` high, an access reaches the configuration/status register. With `reg_sel` low, a write reaches the transmit register. With `reg_sel` low, a read returns the bus A receive word when (`chan_pin` OR configuration bit 5) is 0, and the bus B word when it is 1.
- R2: A write to the transmit register is captured at the first rising clock edge at which `strobe_n` is low after being high. On the next cycle `tx_load` is high for exactly one cycle. At that point `tx_word` holds the data, `tx_cmd_sync` = `hsync` OR configuration bit 4, and `tx_on_b` = `chan_pin` OR configuration bit 5. All three are sampled at the capture edge.
- R3: Configuration bits 5:0 are read/write and take effect after the capture edge. Bit 0 disables transmit on bus A and bit 1 on bus B (the `txdis` port, bit 0 = A). Bit 2 enables bus A receive and bit 3 bus B receive (the `ren` port, bit 0 = A). Bit 4 is the transmit sync (1 = command) and bit 5 is the channel (1 = bus B). Writes to bits 15:6 have no effect.
- R4: Status bits are read-only. Bit 6 reads 0. Bits 7, 8, 9 and 10 are the bus A received flag, sync type (1 = command), idle flag and error flag. Bits 11 to 14 carry the same for bus B. Bit 15 is `tx_ready`, registered once.
- R5: Master reset (`mrst` high at a clock edge) sets the configuration to 0x0C. It clears both receive words, sync types, received flags and error flags, sets both idle flags, and clears the transmit register and `tx_load`. A status read right after reset, with `tx_ready` low, returns 0x220C.
- R6: `hdata` and `hsync` are driven only while `strobe_n` is low and `rd_wr` is high, and are released otherwise, so host write data reaches the block unchanged. A receive read drives the stored sync type of the selected word on `hsync`. A status read drives 0 on `hsync`.
- R7: A receive read clears that bus's received flag on the clock edge at which `strobe_n` is first seen high again. The bus used is the one selected when the strobe fell. The stored word stays readable.
- R8: A `dec_valid` pulse on an enabled bus loads the word and sync type, sets the received flag and clears the error flag. A `dec_start` pulse on an enabled bus clears the received flag. A valid pulse wins over a clear in the same cycle.
- R9: A `dec_err` pulse on an enabled bus sets that bus's error flag and leaves the received flag unchanged. `err_any` is the OR of both error flags.
- R10: While a bus's receive enable is 0, its `dec_valid`, `dec_start` and `dec_err` pulses have no effect, and its idle flag reads 1.
- R11: `rcv[0]` and `rcv[1]` always equal status bits 7 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all host pins are sampled on its rising edge |
| mrst | input | 1 | Master reset, active high, synchronous |
| strobe_n | input | 1 | Access strobe, active low |
| rd_wr | input | 1 | 1 = read, 0 = write |
| reg_sel | input | 1 | 1 = configuration/status register, 0 = data registers |
| chan_pin | input | 1 | Channel select pin, ORed with configuration bit 5 |
| hdata | inout | 16 | Host data bus |
| hsync | inout | 1 | Sync bit beside the data (1 = command sync) |
| tx_load | output | 1 | One-cycle load pulse to the encoder |
| tx_word | output | 16 | Transmit word held for the encoder |
| tx_cmd_sync | output | 1 | Sync type for the transmit word (1 = command) |
| tx_on_b | output | 1 | Target bus for the transmit word (1 = bus B) |
| tx_ready | input | 1 | Encoder ready for a contiguous next word |
| txdis | output | 2 | Transmit disables, bit 0 = bus A |
| ren | output | 2 | Receive enables, bit 0 = bus A |
| dec_valid | input | 2 | Valid word pulse per bus |
| dec_word | input | 32 | Decoded words, bits 15:0 bus A, 31:16 bus B |
| dec_cmd | input | 2 | Sync type of the decoded word per bus |
| dec_start | input | 2 | New-word-arriving pulse per bus |
| dec_gap | input | 2 | Bus idle level per bus |
| dec_err | input | 2 | Encoding error pulse per bus |
| rcv | output | 2 | Received flags, bit 0 = bus A |
| err_any | output | 1 | OR of both bus error flags |

## Verification
Read data and the read sync are combinational from the held pins and registered state, so they are valid from the first falling clock edge after the strobe goes low. Writes, decoder pulses, the ready level and master reset each act at a single rising edge and show at the outputs right after it. `tx_load` is high in the cycle that follows the capture edge. The received flag drops at the edge that first sees the strobe high again. The bench steps a behavioural reference model at every rising edge and compares every output at the following falling edge, so each result is sampled in the cycle it is due and never a cycle early. Directed accesses add hand-computed status words and receive words at the points where the requirements' corner cases meet.

// File: rtl/hostif_pkg.sv
package hostif_pkg;
    localparam int HW          = 16;
    localparam int NBUS        = 2;
    localparam int BW          = (NBUS > 1) ? $clog2(NBUS) : 1;
    localparam int CFG_W       = 6;
    localparam int STAT_BASE   = 7;
    localparam int STAT_STRIDE = 4;
    localparam int TXRDY_BIT   = 15;

    // Field order matches the host bit positions 5..0.
    typedef struct packed {
        logic            chan;
        logic            txsync;
        logic [NBUS-1:0] ren;
        logic [NBUS-1:0] txdis;
    } cfg_t;

    localparam cfg_t CFG_RST = '{chan: 1'b0, txsync: 1'b0, ren: '1, txdis: '0};

    typedef struct packed {
        logic [HW-1:0] word;
        logic          cmd;
        logic          rcv;
        logic          gap;
        logic          err;
    } rxst_t;
endpackage

// File: rtl/hostif_access.sv
module hostif_access
    import hostif_pkg::*;
(
    input  logic            clk,
    input  logic            mrst,
    input  logic            strobe_n,
    input  logic            rd_wr,
    input  logic            reg_sel,
    input  logic            chan_eff,
    output logic            wr_cfg,
    output logic            wr_tx,
    output logic [NBUS-1:0] rd_clr,
    output logic            drive
);
    typedef struct packed {
        logic          strb;
        logic          rx_pend;
        logic [BW-1:0] bus;
    } acc_t;

    acc_t st_q, st_d;
    logic fall, rise;

    always_comb begin
        fall   = st_q.strb & ~strobe_n;
        rise   = ~st_q.strb & strobe_n;
        st_d   = st_q;
        st_d.strb = strobe_n;
        wr_cfg = fall & ~rd_wr & reg_sel;
        wr_tx  = fall & ~rd_wr & ~reg_sel;
        rd_clr = '0;
        if (fall & rd_wr & ~reg_sel) begin
            st_d.rx_pend = 1'b1;
            st_d.bus     = BW'(chan_eff);
        end
        if (rise) begin
            st_d.rx_pend = 1'b0;
            if (st_q.rx_pend) rd_clr[st_q.bus] = 1'b1;
        end
        drive = ~strobe_n & rd_wr;
    end

    always_ff @(posedge clk) begin
        if (mrst) st_q <= '{strb: 1'b1, rx_pend: 1'b0, bus: '0};
        else      st_q <= st_d;
    end
endmodule

// File: rtl/hostif_rxchan.sv
module hostif_rxchan
    import hostif_pkg::*;
(
    input  logic          clk,
    input  logic          mrst,
    input  logic          en,
    input  logic          valid,
    input  logic [HW-1:0] word_in,
    input  logic          cmd_in,
    input  logic          start,
    input  logic          gap_in,
    input  logic          err_in,
    input  logic          rd_clr,
    output rxst_t         st
);
    rxst_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (en & valid) begin
            st_d.word = word_in;
            st_d.cmd  = cmd_in;
            st_d.rcv  = 1'b1;
            st_d.err  = 1'b0;
        end else begin
            if (rd_clr | (en & start)) st_d.rcv = 1'b0;
            if (en & err_in)           st_d.err = 1'b1;
        end
        st_d.gap = gap_in | ~en;
    end

    always_ff @(posedge clk) begin
        if (mrst) st_q <= '{word: '0, cmd: 1'b0, rcv: 1'b0, gap: 1'b1, err: 1'b0};
        else      st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/hostif_regs.sv
module hostif_regs
    import hostif_pkg::*;
(
    input  logic               clk,
    input  logic               mrst,
    input  logic               strobe_n,
    input  logic               rd_wr,
    input  logic               reg_sel,
    input  logic               chan_pin,
    inout  wire  [HW-1:0]      hdata,
    inout  wire                hsync,
    output logic               tx_load,
    output logic [HW-1:0]      tx_word,
    output logic               tx_cmd_sync,
    output logic               tx_on_b,
    input  logic               tx_ready,
    output logic [NBUS-1:0]    txdis,
    output logic [NBUS-1:0]    ren,
    input  logic [NBUS-1:0]    dec_valid,
    input  logic [NBUS*HW-1:0] dec_word,
    input  logic [NBUS-1:0]    dec_cmd,
    input  logic [NBUS-1:0]    dec_start,
    input  logic [NBUS-1:0]    dec_gap,
    input  logic [NBUS-1:0]    dec_err,
    output logic [NBUS-1:0]    rcv,
    output logic               err_any
);
    typedef struct packed {
        cfg_t          cfg;
        logic [HW-1:0] txw;
        logic          txc;
        logic          txb;
        logic          load;
        logic          txrdy;
    } top_t;

    top_t q, d;

    logic                     chan_eff;
    logic                     wr_cfg, wr_tx, drive;
    logic [NBUS-1:0]          rd_clr;
    rxst_t                    rx_st [NBUS];
    logic [NBUS-1:0][HW-1:0]  rx_word;
    logic [NBUS-1:0]          rx_cmd, rx_rcv, rx_gap, rx_err;
    logic [HW-1:0]            stat, rd_word;
    logic                     rd_sync;

    assign chan_eff = chan_pin | q.cfg.chan;

    hostif_access u_acc (
        .clk      (clk),
        .mrst     (mrst),
        .strobe_n (strobe_n),
        .rd_wr    (rd_wr),
        .reg_sel  (reg_sel),
        .chan_eff (chan_eff),
        .wr_cfg   (wr_cfg),
        .wr_tx    (wr_tx),
        .rd_clr   (rd_clr),
        .drive    (drive)
    );

    for (genvar b = 0; b < NBUS; b++) begin : g_rx
        hostif_rxchan u_rx (
            .clk     (clk),
            .mrst    (mrst),
            .en      (q.cfg.ren[b]),
            .valid   (dec_valid[b]),
            .word_in (dec_word[b*HW +: HW]),
            .cmd_in  (dec_cmd[b]),
            .start   (dec_start[b]),
            .gap_in  (dec_gap[b]),
            .err_in  (dec_err[b]),
            .rd_clr  (rd_clr[b]),
            .st      (rx_st[b])
        );
        assign rx_word[b] = rx_st[b].word;
        assign rx_cmd[b]  = rx_st[b].cmd;
        assign rx_rcv[b]  = rx_st[b].rcv;
        assign rx_gap[b]  = rx_st[b].gap;
        assign rx_err[b]  = rx_st[b].err;
    end

    always_comb begin
        d       = q;
        d.load  = 1'b0;
        d.txrdy = tx_ready;
        if (wr_cfg) d.cfg = cfg_t'(hdata[CFG_W-1:0]);
        if (wr_tx) begin
            d.txw  = hdata;
            d.txc  = hsync | q.cfg.txsync;
            d.txb  = chan_eff;
            d.load = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (mrst) q <= '{cfg: CFG_RST, txw: '0, txc: 1'b0, txb: 1'b0, load: 1'b0, txrdy: 1'b0};
        else      q <= d;
    end

    always_comb begin
        stat = '0;
        stat[CFG_W-1:0] = q.cfg;
        for (int b = 0; b < NBUS; b++) begin
            stat[STAT_BASE + STAT_STRIDE*b + 0] = rx_rcv[b];
            stat[STAT_BASE + STAT_STRIDE*b + 1] = rx_cmd[b];
            stat[STAT_BASE + STAT_STRIDE*b + 2] = rx_gap[b];
            stat[STAT_BASE + STAT_STRIDE*b + 3] = rx_err[b];
        end
        stat[TXRDY_BIT] = q.txrdy;
    end

    always_comb begin
        if (reg_sel) begin
            rd_word = stat;
            rd_sync = 1'b0;
        end else begin
            rd_word = rx_word[chan_eff];
            rd_sync = rx_cmd[chan_eff];
        end
    end

    assign hdata = drive ? rd_word : {HW{1'bz}};
    assign hsync = drive ? rd_sync : 1'bz;

    assign tx_load     = q.load;
    assign tx_word     = q.txw;
    assign tx_cmd_sync = q.txc;
    assign tx_on_b     = q.txb;
    assign txdis       = q.cfg.txdis;
    assign ren         = q.cfg.ren;
    assign rcv         = rx_rcv;
    assign err_any     = |rx_err;
endmodule

// File: rtl/hostif_regs_chk.sv
module hostif_regs_chk
    import hostif_pkg::*;
(
    input logic            clk,
    input logic            mrst,
    input logic            strobe_n,
    input logic            rd_wr,
    input logic            reg_sel,
    input logic            chan_eff,
    input logic [HW-1:0]   hdata,
    input logic            tx_load,
    input logic [NBUS-1:0] dec_valid,
    input logic [NBUS-1:0] dec_err,
    input logic [NBUS-1:0] ren,
    input logic [NBUS-1:0] rcv,
    input logic            err_any,
    input logic [NBUS-1:0] gap,
    input logic [HW-1:0]   rxa
);
    assert_txload_pulse_R2: assert property (@(posedge clk) disable iff (mrst)
        tx_load |=> !tx_load);

    assert_txload_src_R2: assert property (@(posedge clk) disable iff (mrst)
        tx_load |-> $past(!strobe_n && !rd_wr && !reg_sel));

    assert_cfg_only_by_write_R3: assert property (@(posedge clk) disable iff (mrst)
        (!$stable(ren) && !$past(mrst)) |-> $past(!strobe_n && !rd_wr && reg_sel));

    assert_read_rxa_R1: assert property (@(posedge clk) disable iff (mrst)
        (!strobe_n && rd_wr && !reg_sel && !chan_eff) |-> (hdata == rxa));

    assert_err_src_R9: assert property (@(posedge clk) disable iff (mrst)
        $rose(err_any) |-> $past(|dec_err));

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        assert_rcv_src_R8: assert property (@(posedge clk) disable iff (mrst)
            $rose(rcv[b]) |-> $past(dec_valid[b] && ren[b]));

        assert_gap_off_R10: assert property (@(posedge clk) disable iff (mrst)
            !ren[b] |=> gap[b]);
    end
endmodule

bind hostif_regs hostif_regs_chk u_chk (
    .clk       (clk),
    .mrst      (mrst),
    .strobe_n  (strobe_n),
    .rd_wr     (rd_wr),
    .reg_sel   (reg_sel),
    .chan_eff  (chan_eff),
    .hdata     (hdata),
    .tx_load   (tx_load),
    .dec_valid (dec_valid),
    .dec_err   (dec_err),
    .ren       (ren),
    .rcv       (rcv),
    .err_any   (err_any),
    .gap       (rx_gap),
    .rxa       (rx_word[0])
);

// File: tb/tb_hostif_regs.sv
`timescale 1ns/1ps
module tb_hostif_regs;
    logic        clk = 1'b0;
    logic        mrst = 1'b1;
    logic        strobe_n = 1'b1, rd_wr = 1'b0, reg_sel = 1'b0, chan_pin = 1'b0;
    logic        tx_ready = 1'b0;
    logic [1:0]  dec_valid = '0, dec_cmd = '0, dec_start = '0, dec_err = '0, dec_gap = 2'b11;
    logic [31:0] dec_word = '0;
    logic        host_en = 1'b0, host_s = 1'b0;
    logic [15:0] host_d = '0;
    wire  [15:0] hdata;
    wire         hsync;
    logic        tx_load, tx_cmd_sync, tx_on_b, err_any;
    logic [15:0] tx_word;
    logic [1:0]  txdis, ren, rcv;

    assign hdata = host_en ? host_d : 16'bz;
    assign hsync = host_en ? host_s : 1'bz;

    always #10 clk = ~clk;

    hostif_regs dut (
        .clk(clk), .mrst(mrst), .strobe_n(strobe_n), .rd_wr(rd_wr), .reg_sel(reg_sel),
        .chan_pin(chan_pin), .hdata(hdata), .hsync(hsync), .tx_load(tx_load),
        .tx_word(tx_word), .tx_cmd_sync(tx_cmd_sync), .tx_on_b(tx_on_b), .tx_ready(tx_ready),
        .txdis(txdis), .ren(ren), .dec_valid(dec_valid), .dec_word(dec_word),
        .dec_cmd(dec_cmd), .dec_start(dec_start), .dec_gap(dec_gap), .dec_err(dec_err),
        .rcv(rcv), .err_any(err_any)
    );

    int total = 0, bad = 0;
    bit cmp_on = 0, rnd_on = 0, done = 0;

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Behavioural reference model
    bit [5:0]  m_cfg;
    bit [15:0] m_w [2];
    bit        m_c [2], m_r [2], m_g [2], m_e [2];
    bit        m_prev, m_pend, m_pbus, m_load, m_txc, m_txb, m_rdy;
    bit [15:0] m_txw;
    bit        mf, mr, mch;

    function automatic bit [15:0] m_stat();
        return {m_rdy, m_e[1], m_g[1], m_c[1], m_r[1], m_e[0], m_g[0], m_c[0], m_r[0], 1'b0, m_cfg};
    endfunction

    always @(posedge clk) begin
        if (mrst) begin
            m_cfg <= 6'h0C;
            for (int b = 0; b < 2; b++) begin
                m_w[b] <= '0; m_c[b] <= 0; m_r[b] <= 0; m_g[b] <= 1; m_e[b] <= 0;
            end
            m_prev <= 1; m_pend <= 0; m_pbus <= 0; m_load <= 0;
            m_txw <= '0; m_txc <= 0; m_txb <= 0; m_rdy <= 0;
        end else begin
            mf  = m_prev && !strobe_n;
            mr  = !m_prev && strobe_n;
            mch = chan_pin | m_cfg[5];
            m_prev <= strobe_n;
            m_rdy  <= tx_ready;
            m_load <= 0;
            if (mf && !rd_wr && reg_sel) m_cfg <= hdata[5:0];
            if (mf && !rd_wr && !reg_sel) begin
                m_txw <= hdata; m_txc <= hsync | m_cfg[4]; m_txb <= mch; m_load <= 1;
            end
            if (mf && rd_wr && !reg_sel) begin m_pend <= 1; m_pbus <= mch; end
            if (mr) m_pend <= 0;
            for (int b = 0; b < 2; b++) begin
                bit en, clr;
                en  = m_cfg[2+b];
                clr = mr && m_pend && (m_pbus == b[0]);
                if (en && dec_valid[b]) begin
                    m_w[b] <= dec_word[b*16 +: 16]; m_c[b] <= dec_cmd[b]; m_r[b] <= 1; m_e[b] <= 0;
                end else begin
                    if (clr || (en && dec_start[b])) m_r[b] <= 0;
                    if (en && dec_err[b]) m_e[b] <= 1;
                end
                m_g[b] <= dec_gap[b] | !en;
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    bit cch;
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk("R2 tx_load", {15'b0, tx_load}, {15'b0, m_load});
            chk("R2 tx_word", tx_word, m_txw);
            chk("R2 tx_cmd_sync", {15'b0, tx_cmd_sync}, {15'b0, m_txc});
            chk("R2 tx_on_b", {15'b0, tx_on_b}, {15'b0, m_txb});
            chk("R3 txdis", {14'b0, txdis}, {14'b0, m_cfg[1:0]});
            chk("R3 ren", {14'b0, ren}, {14'b0, m_cfg[3:2]});
            chk("R11 rcv pins", {14'b0, rcv}, {14'b0, m_r[1], m_r[0]});
            chk("R9 err_any", {15'b0, err_any}, {15'b0, m_e[0] | m_e[1]});
            if (!strobe_n && rd_wr) begin
                cch = chan_pin | m_cfg[5];
                if (reg_sel) begin
                    chk("R4 status read", hdata, m_stat());
                    chk("R6 status sync", {15'b0, hsync}, 16'h0);
                end else begin
                    chk("R1 rx read", hdata, m_w[cch]);
                    chk("R6 rx sync", {15'b0, hsync}, {15'b0, m_c[cch]});
                end
            end
        end
    end

    // Random decoder activity for the second phase
    always @(negedge clk) begin
        if (rnd_on) begin
            #1;
            for (int b = 0; b < 2; b++) begin
                dec_valid[b] = ($urandom_range(0, 11) == 0);
                dec_start[b] = ($urandom_range(0, 13) == 0);
                dec_err[b]   = ($urandom_range(0, 23) == 0);
                dec_gap[b]   = $urandom_range(0, 1) == 1;
                dec_cmd[b]   = $urandom_range(0, 1) == 1;
            end
            dec_word = $urandom;
            tx_ready = $urandom_range(0, 1) == 1;
        end
    end

    task automatic host_write(input bit sel, input logic [15:0] dv, input bit sv, input bit ch);
        @(negedge clk); #1;
        reg_sel = sel; rd_wr = 0; chan_pin = ch; host_d = dv; host_s = sv; host_en = 1; strobe_n = 0;
        repeat (2) @(negedge clk);
        #1 strobe_n = 1;
        @(negedge clk); #1 host_en = 0;
    endtask

    task automatic host_read(input bit sel, input bit ch, output logic [15:0] dv, output logic sv);
        @(negedge clk); #1;
        reg_sel = sel; rd_wr = 1; chan_pin = ch; strobe_n = 0;
        repeat (2) @(negedge clk);
        dv = hdata; sv = hsync;
        #1 strobe_n = 1;
        @(negedge clk); #1 rd_wr = 0;
    endtask

    task automatic dec_pulse_valid(input int b, input logic [15:0] w, input bit c);
        @(negedge clk); #1;
        dec_valid[b] = 1; dec_word[b*16 +: 16] = w; dec_cmd[b] = c;
        @(negedge clk); #1 dec_valid[b] = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        logic        rs;
        @(posedge clk); @(posedge clk);
        cmp_on = 1;
        @(negedge clk); #1 mrst = 0;

        // R5: reset state
        host_read(1, 0, rd, rs);
        chk("R5 reset status", rd, 16'h220C);
        host_read(0, 0, rd, rs);
        chk("R5 reset rx A word", rd, 16'h0000);

        // R3: config bits, upper bits ignored
        host_write(1, 16'hFFFF, 0, 0);
        host_read(1, 0, rd, rs);
        chk("R3 config readback", rd, 16'h223F);
        chk("R3 txdis port", {14'b0, txdis}, 16'h0003);
        host_write(1, 16'h000C, 0, 0);

        // R4: ready flag in bit 15
        @(negedge clk); #1 tx_ready = 1;
        host_read(1, 0, rd, rs);
        chk("R4 ready bit", rd, 16'hA20C);
        @(negedge clk); #1 tx_ready = 0;

        // R8/R1/R6/R7: receive on A, read, flag clears
        dec_pulse_valid(0, 16'h1234, 1);
        @(negedge clk);
        chk("R8 rcv A set", {14'b0, rcv}, 16'h0001);
        host_read(1, 0, rd, rs);
        chk("R4 status with A word", rd, 16'h238C);
        host_read(0, 0, rd, rs);
        chk("R1 rx A data", rd, 16'h1234);
        chk("R6 rx A sync", {15'b0, rs}, 16'h0001);
        @(negedge clk);
        chk("R7 rcv A cleared after read", {14'b0, rcv}, 16'h0000);
        host_read(0, 0, rd, rs);
        chk("R7 word kept after read", rd, 16'h1234);

        // R1: bus B selected through config channel bit
        host_write(1, 16'h002C, 0, 0);
        dec_pulse_valid(1, 16'hBEEF, 0);
        host_read(0, 0, rd, rs);
        chk("R1 rx B via config bit", rd, 16'hBEEF);
        chk("R6 rx B sync", {15'b0, rs}, 16'h0000);
        host_write(1, 16'h000C, 0, 0);

        // R8: start clears flag
        dec_pulse_valid(0, 16'h5555, 0);
        @(negedge clk); #1 dec_start[0] = 1;
        @(negedge clk); #1 dec_start[0] = 0;
        @(negedge clk);
        chk("R8 start clears rcv A", {14'b0, rcv}, 16'h0000);

        // R9: error on B, then cleared by a valid word
        @(negedge clk); #1 dec_err[1] = 1;
        @(negedge clk); #1 dec_err[1] = 0;
        @(negedge clk);
        chk("R9 err_any set", {15'b0, err_any}, 16'h0001);
        chk("R9 rcv not set by error", {14'b0, rcv}, 16'h0000);
        dec_pulse_valid(1, 16'h1111, 1);
        @(negedge clk);
        chk("R9 err cleared by valid", {15'b0, err_any}, 16'h0000);

        // R10: receiver A disabled
        host_write(1, 16'h0008, 0, 0);
        @(negedge clk); #1 dec_gap[0] = 0;
        dec_pulse_valid(0, 16'h7777, 1);
        @(negedge clk); #1 dec_err[0] = 1;
        @(negedge clk); #1 dec_err[0] = 0;
        @(negedge clk);
        chk("R10 disabled A no flag", {14'b0, rcv}, 16'h0002);
        host_read(1, 0, rd, rs);
        chk("R10 disabled A status", rd, 16'h3A08);
        host_read(0, 0, rd, rs);
        chk("R10 disabled A word kept", rd, 16'h5555);
        host_write(1, 16'h000C, 0, 0);
        @(negedge clk); #1 dec_gap[0] = 1;

        // R2/R6: transmit writes
        host_write(0, 16'hA5A5, 0, 1);
        chk("R2 tx word via pin channel", tx_word, 16'hA5A5);
        chk("R2 tx data sync", {15'b0, tx_cmd_sync}, 16'h0000);
        chk("R2 tx bus B", {15'b0, tx_on_b}, 16'h0001);
        host_write(1, 16'h001C, 0, 0);
        host_write(0, 16'h0F0F, 0, 0);
        chk("R6 host write data reached block", tx_word, 16'h0F0F);
        chk("R2 tx sync from config bit", {15'b0, tx_cmd_sync}, 16'h0001);
        chk("R2 tx bus A", {15'b0, tx_on_b}, 16'h0000);

        // R5: master reset mid-run
        @(negedge clk); #1 mrst = 1;
        @(negedge clk); #1 mrst = 0;
        host_read(1, 0, rd, rs);
        chk("R5 status after mid reset", rd, 16'h220C);
        host_read(0, 1, rd, rs);
        chk("R5 rx B cleared", rd, 16'h0000);

        // Random phase against the model
        rnd_on = 1;
        for (int i = 0; i < 400; i++) begin
            case ($urandom_range(0, 4))
                0: host_write(1, 16'($urandom_range(0, 63)), 0, 0);
                1: host_write(0, 16'($urandom), $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
                2: host_read(1, $urandom_range(0, 1) == 1, rd, rs);
                3: host_read(0, $urandom_range(0, 1) == 1, rd, rs);
                default: repeat ($urandom_range(1, 4)) @(negedge clk);
            endcase
        end
        rnd_on = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule